// File: doc/BRIEF.md
# SPI-Slave Host Link Controller

This block is the host end of a two-wire-handshake SPI link to an embedded controller. The far side is the SPI master and decides when transfers happen. This block is the SPI slave. It grants each transfer with a low-then-high pulse on an acknowledge line. A second output line tells the master that the host has a command waiting.

In the idle (upstream) mode, every transfer is two bytes. The first byte is a channel tag and the second byte is a data byte. The controller routes the data byte to a per-channel strobe and sends null bytes back.

When a command is requested, the controller raises its command line and waits for a switch-tagged packet. It then preloads the 8-byte command packet and shifts it out on the next transfer. After that it may run a synchronous data phase in either direction, with a length taken from the packet. In sticky mode it chains to the next command without returning to upstream mode. A long timeout abandons a command that does not finish.

The expected byte count changes with each protocol phase: 2 in upstream mode, 8 for a command, N for data. The transmit contents are always loaded before the acknowledge pulse that grants the transfer.

Top module: `hostlink_ctrl`

## Requirements
- R1: After reset, `cmd_o` is 0, `ack_o` is 1, `err_cnt_o` is 0, and the first 2-byte transfer returns two 0x00 bytes on MISO.
- R2: In upstream mode, a 2-byte transfer whose first byte (the tag) is in 2..NUM_CH-1 pulses `ch_valid_o[tag]` for one cycle, with the second byte on `ch_data_o`. MISO carries 0x00 bytes during the transfer.
- R3: The following tags are dropped without any `ch_valid_o` pulse, and each one increments `err_cnt_o`, which saturates: tag 0, any tag >= NUM_CH, and the switch tag (1) when no command is pending.
- R4: Every handled transfer (upstream, command or data) drives `ack_o` low for exactly ACK_LOW_CYC cycles, after which it returns high.
- R5: A `req_valid_i` pulse while no command is pending raises `cmd_o`. On a switch packet, the next 8-byte transfer shifts out `req_pkt_i`, byte k taken from bits [8k+7:8k], byte 0 first, MSB first. At that switch packet, `cmd_o` falls unless `req_sticky_i` is 1.
- R6: When a non-sticky command completes (its synchronous length, byte 2 of the packet, is 0), or when its data phase ends, the controller pulses `done_o` and lowers `cmd_o`. It then returns to 2-byte upstream transfers with null transmit bytes.
- R7: When a sticky command completes, the controller samples `req_pkt_i` and `req_sticky_i` again and shifts out the new packet on the next 8-byte transfer. `cmd_o` then follows the new sticky flag.
- R8: A nonzero synchronous length N (byte 2) starts a data phase of N bytes, whose direction is set by bit 7 of byte 1. With bit 7 = 1, MISO sends `req_sync_tx_i` bytes, byte 0 at bits [7:0]. With bit 7 = 0, MISO sends nulls, and the received bytes appear on `sync_rx_o` (byte k at bits [8k+7:8k], upper bytes 0) when `done_o` pulses. A bit-7 = 1 phase leaves `sync_rx_o` unchanged.
- R9: If TIMEOUT_CYC cycles pass after a request, or after the last handled command-phase transfer, without the command finishing, the controller pulses `timeout_o`, lowers `cmd_o` and returns to upstream mode.
- R10: MOSI is sampled on rising SCLK and MISO changes after falling SCLK. Raising CS resets the bit and byte counters, so an aborted partial frame does not misalign the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| spi_sclk_i | input | 1 | SPI clock from master |
| spi_mosi_i | input | 1 | SPI data from master |
| spi_miso_o | output | 1 | SPI data to master |
| spi_cs_ni | input | 1 | Active-low chip select |
| ack_o | output | 1 | Transfer grant, low pulse then high |
| cmd_o | output | 1 | Command pending / sticky request |
| req_valid_i | input | 1 | Start a command request |
| req_pkt_i | input | 64 | 8-byte command packet |
| req_sticky_i | input | 1 | Chain another command after this one |
| req_sync_tx_i | input | SYNC_MAX*8 | Host-to-device synchronous data |
| ch_data_o | output | 8 | Routed upstream data byte |
| ch_valid_o | output | NUM_CH | Per-channel data strobe |
| err_cnt_o | output | ERR_W | Dropped-packet count, saturating |
| done_o | output | 1 | Command finished pulse |
| timeout_o | output | 1 | Command abandoned pulse |
| sync_rx_o | output | SYNC_MAX*8 | Device-to-host synchronous data |

## Verification
The upstream path is driven with every valid channel tag, with tag 0, with out-of-range tags and with an unsolicited switch tag. This separates correct routing from silent drops and from miscounted errors. The command path is driven with a zero-length non-sticky command, with a sticky command chained to a non-sticky one, and with data phases in both directions. These show whether packet preload, CMD release and the direction of data movement are tied to the right phase. An aborted partial frame checks counter reset on CS. A request that is never serviced checks the timeout recovery.

// File: rtl/hostlink_pkg.sv
package hostlink_pkg;
  typedef enum logic [1:0] {ST_UP, ST_CMD, ST_DATA} link_st_e;
  localparam logic [7:0] TAG_SWITCH = 8'd1;
  localparam int unsigned TAG_FIRST_CH = 2;
  localparam int unsigned PKT_BYTES = 8;
  localparam int unsigned UP_BYTES = 2;
endpackage

// File: rtl/hostlink_spi_slave.sv
module hostlink_spi_slave #(
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             mosi_i,
  input  logic             cs_ni,
  output logic             miso_o,
  output logic [7:0]       rx_byte_o,
  output logic             rx_valid_o,
  output logic [IDX_W-1:0] rx_idx_o,
  output logic [IDX_W-1:0] tx_idx_o,
  input  logic [7:0]       tx_byte_i
);
  localparam int unsigned N_IN = 3;
  localparam logic [N_IN-1:0] IN_RST = 3'b100;  // cs idles high

  logic [N_IN-1:0] raw;
  logic [N_IN-1:0] s1, s2, s3;
  assign raw = {cs_ni, mosi_i, sclk_i};

  for (genvar g = 0; g < N_IN; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) begin
        s1[g] <= IN_RST[g];
        s2[g] <= IN_RST[g];
        s3[g] <= IN_RST[g];
      end else begin
        s1[g] <= raw[g];
        s2[g] <= s1[g];
        s3[g] <= s2[g];
      end
  end

  logic cs_act, cs_fall, sck_rise, sck_fall, mosi_s;
  assign cs_act   = !s2[2];
  assign cs_fall  = s3[2] && !s2[2];
  assign sck_rise = cs_act && !s3[0] && s2[0];
  assign sck_fall = cs_act && s3[0] && !s2[0];
  assign mosi_s   = s2[1];

  logic [2:0]       bit_cnt;
  logic [6:0]       shreg;
  logic [IDX_W-1:0] byte_idx;
  logic             miso_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      bit_cnt    <= '0;
      shreg      <= '0;
      byte_idx   <= '0;
      rx_byte_o  <= '0;
      rx_valid_o <= 1'b0;
      rx_idx_o   <= '0;
      miso_q     <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (!cs_act) begin
        bit_cnt  <= '0;
        byte_idx <= '0;
      end else begin
        if (sck_rise) begin
          shreg   <= {shreg[5:0], mosi_s};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            rx_byte_o  <= {shreg, mosi_s};
            rx_valid_o <= 1'b1;
            rx_idx_o   <= byte_idx;
            if (byte_idx != '1) byte_idx <= byte_idx + 1'b1;
          end
        end
        if (cs_fall) miso_q <= tx_byte_i[7];
        else if (sck_fall) miso_q <= tx_byte_i[~bit_cnt];
      end
    end

  assign tx_idx_o = byte_idx;
  assign miso_o   = cs_act & miso_q;
endmodule

// File: rtl/hostlink_ack_pulse.sv
module hostlink_ack_pulse #(
  parameter int unsigned LOW_CYC = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic ack_o
);
  localparam int unsigned CNT_W = $clog2(LOW_CYC + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt   <= '0;
      ack_o <= 1'b1;
    end else if (go_i) begin
      cnt   <= CNT_W'(LOW_CYC);
      ack_o <= 1'b0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
      if (cnt == CNT_W'(1)) ack_o <= 1'b1;
    end
endmodule

// File: rtl/hostlink_ctrl.sv
module hostlink_ctrl #(
  parameter int unsigned NUM_CH      = 7,
  parameter int unsigned SYNC_MAX    = 8,
  parameter int unsigned ERR_W       = 8,
  parameter int unsigned ACK_LOW_CYC = 125,
  parameter int unsigned TIMEOUT_CYC = 125_000_000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  spi_sclk_i,
  input  logic                  spi_mosi_i,
  output logic                  spi_miso_o,
  input  logic                  spi_cs_ni,
  output logic                  ack_o,
  output logic                  cmd_o,
  input  logic                  req_valid_i,
  input  logic [63:0]           req_pkt_i,
  input  logic                  req_sticky_i,
  input  logic [SYNC_MAX*8-1:0] req_sync_tx_i,
  output logic [7:0]            ch_data_o,
  output logic [NUM_CH-1:0]     ch_valid_o,
  output logic [ERR_W-1:0]      err_cnt_o,
  output logic                  done_o,
  output logic                  timeout_o,
  output logic [SYNC_MAX*8-1:0] sync_rx_o
);
  import hostlink_pkg::*;

  localparam int unsigned MAXB  = (SYNC_MAX > PKT_BYTES) ? SYNC_MAX : PKT_BYTES;
  localparam int unsigned IDX_W = $clog2(MAXB + 1) + 1;
  localparam int unsigned TMO_W = $clog2(TIMEOUT_CYC + 1);

  logic [7:0]       rx_byte;
  logic             rx_valid;
  logic [IDX_W-1:0] rx_idx, tx_idx;
  logic [7:0]       tx_byte;
  logic             ack_go;

  hostlink_spi_slave #(.IDX_W(IDX_W)) u_spi (
    .clk_i, .rst_ni,
    .sclk_i(spi_sclk_i), .mosi_i(spi_mosi_i), .cs_ni(spi_cs_ni), .miso_o(spi_miso_o),
    .rx_byte_o(rx_byte), .rx_valid_o(rx_valid), .rx_idx_o(rx_idx),
    .tx_idx_o(tx_idx), .tx_byte_i(tx_byte)
  );

  hostlink_ack_pulse #(.LOW_CYC(ACK_LOW_CYC)) u_ack (
    .clk_i, .rst_ni, .go_i(ack_go), .ack_o
  );

  link_st_e             state;
  logic [IDX_W-1:0]     exp_cnt, len_q;
  logic                 pend_q, sticky_q, dir_q;
  logic [MAXB*8-1:0]    tx_vec;
  logic [SYNC_MAX*8-1:0] rx_vec, rx_next;
  logic [TMO_W-1:0]     tmo_cnt;
  logic [IDX_W-1:0]     req_len;
  logic                 xfer_end, fin_now, tag_ok;
  logic [7:0]           tag;

  // transmit byte for current index, null beyond buffer
  always_comb begin
    tx_byte = 8'h00;
    for (int k = 0; k < MAXB; k++)
      if (tx_idx == IDX_W'(k)) tx_byte = tx_vec[8*k +: 8];
  end

  // received data with the just-finished byte merged, zeroed past length
  always_comb begin
    for (int k = 0; k < SYNC_MAX; k++) begin
      rx_next[8*k +: 8] = (rx_idx == IDX_W'(k)) ? rx_byte : rx_vec[8*k +: 8];
      if (IDX_W'(k) >= exp_cnt) rx_next[8*k +: 8] = 8'h00;
    end
  end

  assign req_len  = (req_pkt_i[23:16] > 8'(SYNC_MAX)) ? IDX_W'(SYNC_MAX) : IDX_W'(req_pkt_i[23:16]);
  assign xfer_end = rx_valid && (rx_idx == exp_cnt - IDX_W'(1));
  assign tag      = rx_vec[7:0];
  assign tag_ok   = (tag >= 8'(TAG_FIRST_CH)) && (tag < 8'(NUM_CH));
  assign fin_now  = xfer_end && (((state == ST_CMD) && (len_q == '0)) || (state == ST_DATA));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state      <= ST_UP;
      exp_cnt    <= IDX_W'(UP_BYTES);
      len_q      <= '0;
      pend_q     <= 1'b0;
      sticky_q   <= 1'b0;
      dir_q      <= 1'b0;
      cmd_o      <= 1'b0;
      tx_vec     <= '0;
      rx_vec     <= '0;
      tmo_cnt    <= '0;
      ch_data_o  <= '0;
      ch_valid_o <= '0;
      err_cnt_o  <= '0;
      done_o     <= 1'b0;
      timeout_o  <= 1'b0;
      sync_rx_o  <= '0;
      ack_go     <= 1'b0;
    end else begin
      ch_valid_o <= '0;
      done_o     <= 1'b0;
      timeout_o  <= 1'b0;
      ack_go     <= 1'b0;

      for (int k = 0; k < SYNC_MAX; k++)
        if (rx_valid && rx_idx == IDX_W'(k)) rx_vec[8*k +: 8] <= rx_byte;

      if (pend_q) tmo_cnt <= tmo_cnt + 1'b1;
      if (req_valid_i && !pend_q) begin
        pend_q  <= 1'b1;
        cmd_o   <= 1'b1;
        tmo_cnt <= '0;
      end

      if (xfer_end) begin
        ack_go <= 1'b1;
        unique case (state)
          ST_UP: begin
            if (tag == TAG_SWITCH && pend_q) begin
              tx_vec        <= '0;
              tx_vec[63:0]  <= req_pkt_i;
              len_q         <= req_len;
              dir_q         <= req_pkt_i[15];
              sticky_q      <= req_sticky_i;
              cmd_o         <= req_sticky_i;
              exp_cnt       <= IDX_W'(PKT_BYTES);
              tmo_cnt       <= '0;
              state         <= ST_CMD;
            end else if (tag_ok) begin
              ch_data_o <= rx_byte;
              for (int k = 0; k < NUM_CH; k++) ch_valid_o[k] <= (tag == 8'(k));
            end else if (err_cnt_o != '1) begin
              err_cnt_o <= err_cnt_o + 1'b1;
            end
          end
          ST_CMD: begin
            tmo_cnt <= '0;
            if (len_q != '0) begin
              tx_vec <= '0;
              if (dir_q) tx_vec[SYNC_MAX*8-1:0] <= req_sync_tx_i;
              exp_cnt <= len_q;
              state   <= ST_DATA;
            end
          end
          ST_DATA: begin
            tmo_cnt <= '0;
            if (!dir_q) sync_rx_o <= rx_next;
          end
          default: state <= ST_UP;
        endcase

        if (fin_now) begin
          done_o <= 1'b1;
          if (sticky_q) begin
            tx_vec       <= '0;
            tx_vec[63:0] <= req_pkt_i;
            len_q        <= req_len;
            dir_q        <= req_pkt_i[15];
            sticky_q     <= req_sticky_i;
            cmd_o        <= req_sticky_i;
            exp_cnt      <= IDX_W'(PKT_BYTES);
            state        <= ST_CMD;
          end else begin
            tx_vec  <= '0;
            exp_cnt <= IDX_W'(UP_BYTES);
            pend_q  <= 1'b0;
            cmd_o   <= 1'b0;
            state   <= ST_UP;
          end
        end
      end else if (pend_q && tmo_cnt == TMO_W'(TIMEOUT_CYC - 1)) begin
        timeout_o <= 1'b1;
        pend_q    <= 1'b0;
        cmd_o     <= 1'b0;
        tx_vec    <= '0;
        exp_cnt   <= IDX_W'(UP_BYTES);
        state     <= ST_UP;
      end
    end
endmodule

// File: rtl/hostlink_ctrl_chk.sv
module hostlink_ctrl_chk #(
  parameter int unsigned NUM_CH      = 7,
  parameter int unsigned ERR_W       = 8,
  parameter int unsigned ACK_LOW_CYC = 125
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ack_o,
  input logic              cmd_o,
  input logic [NUM_CH-1:0] ch_valid_o,
  input logic [ERR_W-1:0]  err_cnt_o,
  input logic              done_o,
  input logic              timeout_o
);
  int unsigned low_cnt;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) low_cnt <= 0;
    else low_cnt <= ack_o ? 0 : low_cnt + 1;

  assert_ack_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && low_cnt != 0) |-> (low_cnt == ACK_LOW_CYC));
  assert_ack_after_dispatch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ch_valid_o) |=> !ack_o);
  assert_ch_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_valid_o));
  assert_no_reserved_ch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ch_valid_o[0] && !ch_valid_o[1]);
  assert_err_monotonic_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_cnt_o >= $past(err_cnt_o));
  assert_tmo_drops_cmd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !cmd_o);
  assert_done_tmo_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o));
endmodule

bind hostlink_ctrl hostlink_ctrl_chk #(
  .NUM_CH(NUM_CH), .ERR_W(ERR_W), .ACK_LOW_CYC(ACK_LOW_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_o(ack_o), .cmd_o(cmd_o),
  .ch_valid_o(ch_valid_o), .err_cnt_o(err_cnt_o), .done_o(done_o), .timeout_o(timeout_o)
);

// File: tb/hostlink_ctrl_bench.sv
`timescale 1ns/1ps
module hostlink_ctrl_bench;
  localparam int unsigned NUM_CH = 7;
  localparam int unsigned SYNC_MAX = 8;
  localparam int unsigned ERR_W = 8;
  localparam int unsigned ACK_LOW = 40;
  localparam int unsigned TMO = 3000;
  localparam int HALF = 4;

  logic clk = 0, rst_n = 0;
  logic sclk = 0, mosi = 0, cs_n = 1, miso;
  logic ack, cmd, req_valid = 0, req_sticky = 0;
  logic [63:0] req_pkt = '0;
  logic [SYNC_MAX*8-1:0] req_sync = '0, sync_rx;
  logic [7:0] ch_data;
  logic [NUM_CH-1:0] ch_valid;
  logic [ERR_W-1:0] err_cnt;
  logic done, tmo;

  always #4 clk = ~clk;

  hostlink_ctrl #(.NUM_CH(NUM_CH), .SYNC_MAX(SYNC_MAX), .ERR_W(ERR_W),
                  .ACK_LOW_CYC(ACK_LOW), .TIMEOUT_CYC(TMO)) u_hostlink_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .spi_sclk_i(sclk), .spi_mosi_i(mosi), .spi_miso_o(miso),
    .spi_cs_ni(cs_n), .ack_o(ack), .cmd_o(cmd), .req_valid_i(req_valid), .req_pkt_i(req_pkt),
    .req_sticky_i(req_sticky), .req_sync_tx_i(req_sync), .ch_data_o(ch_data),
    .ch_valid_o(ch_valid), .err_cnt_o(err_cnt), .done_o(done), .timeout_o(tmo), .sync_rx_o(sync_rx)
  );

  int n_chk = 0, n_bad = 0, done_cnt = 0, tmo_cnt = 0, low_run = 0;
  logic [15:0] expq[$];
  logic [7:0] mo[16], mi[16];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: scoreboard for channel output, ack width, status pulses
  always @(negedge clk) if (rst_n) begin
    if (|ch_valid) begin
      logic [7:0] t;
      logic [15:0] e;
      t = 8'hFF;
      for (int k = 0; k < NUM_CH; k++) if (ch_valid[k]) t = 8'(k);
      if (expq.size() == 0) check(0, "R2/R3 unexpected dispatch", {48'd0, t, ch_data}, 64'd0);
      else begin
        e = expq.pop_front();
        check({t, ch_data} == e, "R2 dispatch", {48'd0, t, ch_data}, {48'd0, e});
      end
    end
    if (!ack) low_run++;
    else begin
      if (low_run != 0) check(low_run == ACK_LOW, "R4 ack low width", 64'(low_run), 64'(ACK_LOW));
      low_run = 0;
    end
    if (done) done_cnt++;
    if (tmo) tmo_cnt++;
  end

  task automatic xfer(input int n);
    wait (ack);
    @(negedge clk) cs_n = 0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < n; b++)
      for (int i = 7; i >= 0; i--) begin
        mosi = mo[b][i];
        repeat (HALF) @(negedge clk);
        mi[b][i] = miso;
        sclk = 1;
        repeat (HALF) @(negedge clk);
        sclk = 0;
      end
    repeat (HALF) @(negedge clk);
    cs_n = 1;
    repeat (60) @(negedge clk);
  endtask

  task automatic up(input logic [7:0] t, input logic [7:0] d, input bit expect_out);
    mo[0] = t; mo[1] = d;
    if (expect_out) expq.push_back({t, d});
    xfer(2);
    check({mi[0], mi[1]} == 16'h0, "R2 upstream nulls on MISO", {48'd0, mi[0], mi[1]}, 64'd0);
  endtask

  task automatic pkt_xfer(input logic [63:0] exp_pkt, input string req);
    logic [63:0] got;
    for (int b = 0; b < 8; b++) mo[b] = 8'h00;
    xfer(8);
    for (int b = 0; b < 8; b++) got[8*b +: 8] = mi[b];
    check(got == exp_pkt, req, got, exp_pkt);
  endtask

  task automatic request(input logic [63:0] p, input bit st);
    req_pkt = p; req_sticky = st;
    @(negedge clk) req_valid = 1;
    @(negedge clk) req_valid = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    int d0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(ack == 1'b1, "R1 ack idle", 64'(ack), 64'd1);
    check(cmd == 1'b0, "R1 cmd idle", 64'(cmd), 64'd0);
    check(err_cnt == '0, "R1 err zero", 64'(err_cnt), 64'd0);
    // R1/R2 first frame accepted at once, nulls returned
    up(8'd3, 8'hA5, 1);
    up(8'd4, 8'h5A, 1);
    up(8'd6, 8'hC3, 1);
    up(8'd2, 8'h01, 1);
    // R3 drops
    up(8'd0, 8'h11, 0);
    up(8'd7, 8'h22, 0);
    up(8'd200, 8'h33, 0);
    up(8'd1, 8'h00, 0);
    check(err_cnt == 8'd4, "R3 error count", 64'(err_cnt), 64'd4);
    check(expq.size() == 0, "R3 nothing dispatched", 64'(expq.size()), 64'd0);
    // R10 aborted partial frame
    @(negedge clk) cs_n = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      mosi = 1; repeat (HALF) @(negedge clk); sclk = 1; repeat (HALF) @(negedge clk); sclk = 0;
    end
    repeat (HALF) @(negedge clk); cs_n = 1; repeat (20) @(negedge clk);
    up(8'd5, 8'h3C, 1);
    check(err_cnt == 8'd4, "R10 no misalignment after abort", 64'(err_cnt), 64'd4);

    // R5/R6 non-sticky zero-length command
    d0 = done_cnt;
    request(64'h0000_0022_1100_0252, 0);
    check(cmd == 1'b1, "R5 cmd raised", 64'(cmd), 64'd1);
    up(8'd1, 8'h00, 0);
    check(cmd == 1'b0, "R5 cmd dropped at switch", 64'(cmd), 64'd0);
    pkt_xfer(64'h0000_0022_1100_0252, "R5 packet on MISO");
    check(done_cnt == d0 + 1, "R6 done pulse", 64'(done_cnt), 64'(d0 + 1));
    up(8'd3, 8'h77, 1);
    check(err_cnt == 8'd4, "R6 back to upstream", 64'(err_cnt), 64'd4);

    // R7 sticky chain
    d0 = done_cnt;
    request(64'h0000_0000_0000_0140, 1);
    up(8'd1, 8'h00, 0);
    check(cmd == 1'b1, "R7 cmd held while sticky", 64'(cmd), 64'd1);
    req_pkt = 64'h0000_0000_0000_0241; req_sticky = 0;
    pkt_xfer(64'h0000_0000_0000_0140, "R7 first packet");
    check(cmd == 1'b0, "R7 cmd follows next flag", 64'(cmd), 64'd0);
    pkt_xfer(64'h0000_0000_0000_0241, "R7 chained packet");
    check(done_cnt == d0 + 2, "R7 two completions", 64'(done_cnt), 64'(d0 + 2));
    up(8'd4, 8'h99, 1);

    // R8 device-to-host data
    request(64'h0000_0000_0003_0051, 0);
    up(8'd1, 8'h00, 0);
    pkt_xfer(64'h0000_0000_0003_0051, "R8 d2h packet");
    mo[0] = 8'h11; mo[1] = 8'h22; mo[2] = 8'h33;
    xfer(3);
    check({mi[0], mi[1], mi[2]} == 24'h0, "R8 d2h nulls", {40'd0, mi[0], mi[1], mi[2]}, 64'd0);
    check(sync_rx == 64'h33_2211, "R8 d2h data delivered", sync_rx, 64'h33_2211);
    // R8 host-to-device data
    req_sync = 64'h0000_0000_DDCC_BBAA;
    request(64'h0000_0000_0004_8051, 0);
    up(8'd1, 8'h00, 0);
    pkt_xfer(64'h0000_0000_0004_8051, "R8 h2d packet");
    for (int b = 0; b < 4; b++) mo[b] = 8'h00;
    xfer(4);
    check({mi[3], mi[2], mi[1], mi[0]} == 32'hDDCC_BBAA, "R8 h2d data on MISO",
          {32'd0, mi[3], mi[2], mi[1], mi[0]}, 64'hDDCC_BBAA);
    check(sync_rx == 64'h33_2211, "R8 h2d keeps rx data", sync_rx, 64'h33_2211);
    check(cmd == 1'b0, "R6 cmd low after data phase", 64'(cmd), 64'd0);

    // R9 timeout
    request(64'h0000_0000_0000_0010, 0);
    check(cmd == 1'b1, "R9 cmd raised", 64'(cmd), 64'd1);
    repeat (TMO + 200) @(negedge clk);
    check(tmo_cnt == 1, "R9 timeout pulse", 64'(tmo_cnt), 64'd1);
    check(cmd == 1'b0, "R9 cmd dropped", 64'(cmd), 64'd0);
    up(8'd6, 8'h42, 1);
    up(8'd1, 8'h00, 0);
    check(err_cnt == 8'd5, "R9 switch ignored after timeout", 64'(err_cnt), 64'd5);

    repeat (20) @(negedge clk);
    check(expq.size() == 0, "R2 all expected dispatched", 64'(expq.size()), 64'd0);
    finish_run();
  end
endmodule